// File: doc/BRIEF.md
# Cache Maintenance Operation Unit

This unit carries out software-issued cache maintenance commands against the tag and state store of a write-back, set-associative cache. The store keeps a tag, a valid bit, a dirty bit and an age stamp for every line. A command comes in as a 5-bit opcode, an address and a start strobe. The unit takes it only when it is idle and the memory bus has been granted to it. When a command needs a line written back to memory, the unit raises a request to a separate word-serial write-back engine and holds it until that engine reports done. Every start strobe that is not taken is answered with a stall, so the processor retries.

Five kinds of command are supported. Hit-invalidate drops a matching line. The hit-writeback family comes in four variants: plain or invalidating, and normal or forced. Set-line allocation claims a line for a new tag without fetching anything from memory. All other opcode values are taken and do nothing. The ordinary load/store path shares the same store through a lookup port. That port reports hit and dirty status for an address, and when it is strobed it refreshes a line's age and, on writes, marks the line dirty.

Top module: `cache_maint_unit`

## Requirements
- R1: A command is accepted (`opAccept`=1) in the same cycle as `opStart` only if the unit is idle and `busGrant` is high. In every other case, `opStall` equals `opStart && !opAccept`.
- R2: Hit-invalidate (opcode bits [3:0] = 8) clears the valid bit of the matching way when the address hits. On a miss, no line changes.
- R3: Plain hit-writeback (9) on a dirty hit raises `wbReq` in the cycle after acceptance. While it is raised, `wbAddr` is the line base address (tag and index, offset zero) and `wbWay` is the way. `wbReq` stays high until the cycle in which `wbDone` is seen and drops in the next cycle. The line is then valid and clean, and no refill is requested.
- R4: The invalidating writebacks (10 plain, 12 forced) behave as R3, and in addition clear the line's valid bit when the write-back finishes.
- R5: The forced writebacks (11, 12) write back a hit line even when it is clean. The non-forced variants (9, 10) on a clean hit are taken as no-ops.
- R6: Set-line (7) on a miss picks a victim in the indexed set. The victim is the lowest-numbered invalid way, or, if every way is valid, the way with the oldest age stamp (lowest way on a tie). If the victim is not a valid dirty line, the new tag is installed at once, valid and clean, with a fresh age stamp, and no write-back is requested.
- R7: Set-line whose victim is valid and dirty first writes back the victim's old line, with `wbAddr` built from the old tag. Once `wbDone` is seen, the new tag is installed valid and clean in that way.
- R8: Set-line on an address that already hits changes nothing.
- R9: While a write-back is pending, every `opStart` is stalled, and `wbAddr`/`wbWay` hold steady.
- R10: Opcode bit 4 selects the cache: 1 means data, and this unit serves the data cache. Opcodes for the other cache, and function codes 0–6 and 13–15, are accepted in one cycle with no state change and no write-back.
- R11: `accHit`/`accHitDirty` report the lookup of `accAddr` combinationally. A strobed access (`accValid`) that hits refreshes the line's age stamp and, when `accWrite` is set, marks it dirty. A miss changes nothing. After reset, no address hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opStart | input | 1 | Maintenance command strobe |
| opCode | input | 5 | [4] cache select (1 = data), [3:0] function |
| opAddr | input | ADDR_W | Command address |
| busGrant | input | 1 | Memory bus granted to this unit |
| opAccept | output | 1 | Command taken this cycle |
| opStall | output | 1 | Command refused, retry |
| wbReq | output | 1 | Line write-back request to the engine |
| wbWay | output | WAY_W | Way being written back |
| wbAddr | output | ADDR_W | Base address of the line being written back |
| wbDone | input | 1 | Engine finished the line |
| accValid | input | 1 | Load/store access strobe |
| accWrite | input | 1 | Access is a store |
| accAddr | input | ADDR_W | Access address |
| accHit | output | 1 | Access address hits |
| accHitDirty | output | 1 | Hit line is dirty |

## Verification
The assertions take three things for granted about the inputs. `wbDone` is only raised while `wbReq` is high. A load/store strobe never coincides with an accepted command or a pending write-back. Every age stamp update happens in its own cycle, so the saturating age counter does not tie two valid lines. The bench meets these conditions because its tasks serialise everything: accesses, commands and write-back completions each occupy their own cycles, and `wbDone` is only pulsed after `wbReq` has been observed. The run is far shorter than the age counter's range.

// File: rtl/cmu_pkg.sv
package cmu_pkg;

  typedef enum logic [3:0] {
    FN_IDX_INV     = 4'd0,
    FN_IDX_WB      = 4'd1,
    FN_IDX_WBINV   = 4'd2,
    FN_TAG_READ    = 4'd3,
    FN_TAG_WRITE   = 4'd4,
    FN_IDX_FWB     = 4'd5,
    FN_IDX_FWBINV  = 4'd6,
    FN_SETLINE     = 4'd7,
    FN_HIT_INV     = 4'd8,
    FN_HIT_WB      = 4'd9,
    FN_HIT_WBINV   = 4'd10,
    FN_HIT_FWB     = 4'd11,
    FN_HIT_FWBINV  = 4'd12,
    FN_SWAP        = 4'd13,
    FN_SWAP_BACK   = 4'd14,
    FN_SPARE       = 4'd15
  } maint_fn_e;

  // Strobes from control to the tag/state store
  typedef struct packed {
    logic clrValid;
    logic clean;
    logic install;
  } tag_strobe_t;

endpackage

// File: rtl/cmu_tag_path.sv
module cmu_tag_path
  import cmu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int IDX_W   = 2,
  parameter int WAYS    = 2,
  parameter int STAMP_W = 16,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  tag_strobe_t       stb,
  input  logic [WAY_W-1:0]  stbWay,
  input  logic [IDX_W-1:0]  stbIdx,
  input  logic [TAG_W-1:0]  stbTag,
  output logic              opHit,
  output logic [WAY_W-1:0]  opHitWay,
  output logic              opHitDirty,
  output logic [WAY_W-1:0]  vicWay,
  output logic              vicValid,
  output logic              vicDirty,
  output logic [TAG_W-1:0]  vicTag,
  output logic              accHit,
  output logic              accHitDirty
);

  localparam int LINE_W = IDX_W + WAY_W;
  localparam int LINES  = 1 << LINE_W;

  logic [LINES-1:0]   validQ;
  logic [LINES-1:0]   dirtyQ;
  logic [TAG_W-1:0]   tagQ   [LINES];
  logic [STAMP_W-1:0] stampQ [LINES];
  logic [STAMP_W-1:0] stampCnt;

  logic [IDX_W-1:0] opIdx, accIdx;
  logic [TAG_W-1:0] opTag, accTag;
  logic [WAYS-1:0]  opHitVec, accHitVec;
  logic [WAY_W-1:0] accHitWay;
  logic [LINE_W-1:0] stbLine, accLine;

  assign opIdx  = opAddr[OFF_W +: IDX_W];
  assign opTag  = opAddr[ADDR_W-1 -: TAG_W];
  assign accIdx = accAddr[OFF_W +: IDX_W];
  assign accTag = accAddr[ADDR_W-1 -: TAG_W];

  // Per-way tag compare for both lookup ports
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [WAY_W-1:0] WID = WAY_W'(w);
    assign opHitVec[w]  = validQ[{opIdx, WID}]  && (tagQ[{opIdx, WID}]  == opTag);
    assign accHitVec[w] = validQ[{accIdx, WID}] && (tagQ[{accIdx, WID}] == accTag);
  end

  always_comb begin
    opHitWay  = '0;
    accHitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (opHitVec[w])  opHitWay  = WAY_W'(w);
      if (accHitVec[w]) accHitWay = WAY_W'(w);
    end
  end

  assign opHit       = |opHitVec;
  assign opHitDirty  = opHit && dirtyQ[{opIdx, opHitWay}];
  assign accHit      = |accHitVec;
  assign accLine     = {accIdx, accHitWay};
  assign accHitDirty = accHit && dirtyQ[accLine];

  // Victim: lowest invalid way, else oldest stamp (lowest way on tie)
  logic             anyFree;
  logic [WAY_W-1:0] freeWay, oldWay;
  always_comb begin
    anyFree = 1'b0;
    freeWay = '0;
    oldWay  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!validQ[{opIdx, WAY_W'(w)}]) begin
        anyFree = 1'b1;
        freeWay = WAY_W'(w);
      end
    end
    for (int w = 1; w < WAYS; w++) begin
      if (stampQ[{opIdx, WAY_W'(w)}] < stampQ[{opIdx, oldWay}]) oldWay = WAY_W'(w);
    end
  end

  assign vicWay   = anyFree ? freeWay : oldWay;
  assign vicValid = validQ[{opIdx, vicWay}];
  assign vicDirty = dirtyQ[{opIdx, vicWay}];
  assign vicTag   = tagQ[{opIdx, vicWay}];

  assign stbLine = {stbIdx, stbWay};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= '0;
      dirtyQ   <= '0;
      stampCnt <= '0;
      for (int i = 0; i < LINES; i++) begin
        tagQ[i]   <= '0;
        stampQ[i] <= '0;
      end
    end else begin
      if (stampCnt != '1) stampCnt <= stampCnt + 1'b1;
      if (accValid && accHit) begin
        stampQ[accLine] <= stampCnt;
        if (accWrite) dirtyQ[accLine] <= 1'b1;
      end
      if (stb.clean)    dirtyQ[stbLine] <= 1'b0;
      if (stb.clrValid) validQ[stbLine] <= 1'b0;
      if (stb.install) begin
        validQ[stbLine] <= 1'b1;
        dirtyQ[stbLine] <= 1'b0;
        tagQ[stbLine]   <= stbTag;
        stampQ[stbLine] <= stampCnt;
      end
    end
  end

  // R2/R4: an invalidate strobe leaves the line invalid
  p_inv_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrValid |=> !validQ[$past(stbLine)]);

  // R6/R7: an install leaves the line valid, clean and tagged
  p_install_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.install |=> (validQ[$past(stbLine)] && !dirtyQ[$past(stbLine)]
                     && tagQ[$past(stbLine)] == $past(stbTag)));

  // R3: a finished write-back leaves the line clean
  p_clean_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.clean |=> !dirtyQ[$past(stbLine)]);

  // R8: set-line never duplicates a tag inside a set
  p_unique_hit_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(opHitVec) && $onehot0(accHitVec));

endmodule

// File: rtl/cmu_ctrl.sv
module cmu_ctrl
  import cmu_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 4,
  parameter int IDX_W      = 2,
  parameter int WAYS       = 2,
  parameter bit SERVE_DATA = 1'b1,
  localparam int WAY_W     = $clog2(WAYS),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opStart,
  input  logic [4:0]        opCode,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic              busGrant,
  input  logic              opHit,
  input  logic [WAY_W-1:0]  opHitWay,
  input  logic              opHitDirty,
  input  logic [WAY_W-1:0]  vicWay,
  input  logic              vicValid,
  input  logic              vicDirty,
  input  logic [TAG_W-1:0]  vicTag,
  input  logic              wbDone,
  output logic              opAccept,
  output logic              opStall,
  output logic              wbReq,
  output logic [WAY_W-1:0]  wbWay,
  output logic [ADDR_W-1:0] wbAddr,
  output tag_strobe_t       stb,
  output logic [WAY_W-1:0]  stbWay,
  output logic [IDX_W-1:0]  stbIdx,
  output logic [TAG_W-1:0]  stbTag
);

  typedef enum logic {ST_IDLE, ST_WB} ctrl_state_e;

  ctrl_state_e      stateQ;
  logic [WAY_W-1:0] wayQ;
  logic [IDX_W-1:0] idxQ;
  logic [TAG_W-1:0] wbTagQ, newTagQ;
  logic             invAfterQ, installAfterQ;

  logic             launch, launchInv, launchInstall;
  logic [WAY_W-1:0] launchWay;
  logic [TAG_W-1:0] launchTag;
  logic             forMe;
  maint_fn_e        fn;
  logic [IDX_W-1:0] opIdx;
  logic [TAG_W-1:0] opTag;

  assign fn    = maint_fn_e'(opCode[3:0]);
  assign forMe = (opCode[4] == SERVE_DATA);
  assign opIdx = opAddr[OFF_W +: IDX_W];
  assign opTag = opAddr[ADDR_W-1 -: TAG_W];

  assign opAccept = (stateQ == ST_IDLE) && opStart && busGrant;
  assign opStall  = opStart && !opAccept;

  always_comb begin
    stb           = '0;
    stbWay        = '0;
    stbIdx        = opIdx;
    stbTag        = opTag;
    launch        = 1'b0;
    launchInv     = 1'b0;
    launchInstall = 1'b0;
    launchWay     = '0;
    launchTag     = opTag;
    if (stateQ == ST_WB) begin
      stbWay = wayQ;
      stbIdx = idxQ;
      stbTag = newTagQ;
      if (wbDone) begin
        stb.clean    = 1'b1;
        stb.clrValid = invAfterQ;
        stb.install  = installAfterQ;
      end
    end else if (opAccept && forMe) begin
      unique case (fn)
        FN_HIT_INV: begin
          stbWay       = opHitWay;
          stb.clrValid = opHit;
        end
        FN_HIT_WB, FN_HIT_WBINV, FN_HIT_FWB, FN_HIT_FWBINV: begin
          launchWay = opHitWay;
          launchInv = (fn == FN_HIT_WBINV) || (fn == FN_HIT_FWBINV);
          launch    = opHit && (opHitDirty || fn == FN_HIT_FWB || fn == FN_HIT_FWBINV);
        end
        FN_SETLINE: begin
          if (!opHit) begin
            if (vicValid && vicDirty) begin
              launch        = 1'b1;
              launchInstall = 1'b1;
              launchWay     = vicWay;
              launchTag     = vicTag;
            end else begin
              stbWay      = vicWay;
              stb.install = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ        <= ST_IDLE;
      wayQ          <= '0;
      idxQ          <= '0;
      wbTagQ        <= '0;
      newTagQ       <= '0;
      invAfterQ     <= 1'b0;
      installAfterQ <= 1'b0;
    end else if (stateQ == ST_IDLE) begin
      if (launch) begin
        stateQ        <= ST_WB;
        wayQ          <= launchWay;
        idxQ          <= opIdx;
        wbTagQ        <= launchTag;
        newTagQ       <= opTag;
        invAfterQ     <= launchInv;
        installAfterQ <= launchInstall;
      end
    end else if (wbDone) begin
      stateQ <= ST_IDLE;
    end
  end

  assign wbReq  = (stateQ == ST_WB);
  assign wbWay  = wayQ;
  assign wbAddr = {wbTagQ, idxQ, {OFF_W{1'b0}}};

  // R9: request and line address hold until the engine finishes
  p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbDone) |=> (wbReq && $stable(wbAddr) && $stable(wbWay)));

  // R3: request drops the cycle after completion
  p_wb_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && wbDone) |=> !wbReq);

  // R1: a write-back only starts from an accepted command
  p_launch_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wbReq) |-> $past(opAccept));

  // R9: a start during a pending write-back is stalled
  p_busy_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && opStart) |-> (opStall && !opAccept));

endmodule

// File: rtl/cache_maint_unit.sv
module cache_maint_unit
  import cmu_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 4,
  parameter int IDX_W      = 2,
  parameter int WAYS       = 2,
  parameter int STAMP_W    = 16,
  parameter bit SERVE_DATA = 1'b1,
  localparam int WAY_W     = $clog2(WAYS),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opStart,
  input  logic [4:0]        opCode,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic              busGrant,
  output logic              opAccept,
  output logic              opStall,
  output logic              wbReq,
  output logic [WAY_W-1:0]  wbWay,
  output logic [ADDR_W-1:0] wbAddr,
  input  logic              wbDone,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              accHit,
  output logic              accHitDirty
);

  tag_strobe_t      stb;
  logic [WAY_W-1:0] stbWay, opHitWay, vicWay;
  logic [IDX_W-1:0] stbIdx;
  logic [TAG_W-1:0] stbTag, vicTag;
  logic             opHit, opHitDirty, vicValid, vicDirty;

  cmu_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .WAYS(WAYS), .SERVE_DATA(SERVE_DATA)
  ) u_ctrl (
    .clk, .rstN, .opStart, .opCode, .opAddr, .busGrant,
    .opHit, .opHitWay, .opHitDirty, .vicWay, .vicValid, .vicDirty, .vicTag,
    .wbDone, .opAccept, .opStall, .wbReq, .wbWay, .wbAddr,
    .stb, .stbWay, .stbIdx, .stbTag
  );

  cmu_tag_path #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .WAYS(WAYS), .STAMP_W(STAMP_W)
  ) u_path (
    .clk, .rstN, .opAddr, .accValid, .accWrite, .accAddr,
    .stb, .stbWay, .stbIdx, .stbTag,
    .opHit, .opHitWay, .opHitDirty, .vicWay, .vicValid, .vicDirty, .vicTag,
    .accHit, .accHitDirty
  );

endmodule

// File: tb/tb_cache_maint_unit.sv
module tb_cache_maint_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opStart = 1'b0;
  logic [4:0]  opCode = '0;
  logic [15:0] opAddr = '0;
  logic        busGrant = 1'b0;
  logic        opAccept, opStall, wbReq;
  logic [0:0]  wbWay;
  logic [15:0] wbAddr;
  logic        wbDone = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [15:0] accAddr = '0;
  logic        accHit, accHitDirty;

  cache_maint_unit dut (
    .clk, .rstN, .opStart, .opCode, .opAddr, .busGrant, .opAccept, .opStall,
    .wbReq, .wbWay, .wbAddr, .wbDone, .accValid, .accWrite, .accAddr,
    .accHit, .accHitDirty
  );

  always #10 clk = ~clk;  // 50 MHz

  int tests = 0;
  int fails = 0;
  int seq = 0;
  bit mValid [8];
  bit mDirty [8];
  int mTag   [8];
  int mStamp [8];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkAddr(input int t, input int i, input int o);
    return {t[9:0], i[1:0], o[3:0]};
  endfunction

  function automatic int mLookup(input int t, input int i);
    for (int w = 0; w < 2; w++)
      if (mValid[i*2+w] && mTag[i*2+w] == t) return w;
    return -1;
  endfunction

  function automatic int mVictim(input int i);
    int old;
    for (int w = 0; w < 2; w++) if (!mValid[i*2+w]) return w;
    old = 0;
    for (int w = 1; w < 2; w++) if (mStamp[i*2+w] < mStamp[i*2+old]) old = w;
    return old;
  endfunction

  task automatic probe(input int t, input int i, input string req);
    int hw;
    bit expDirty;
    @(negedge clk);
    accAddr = mkAddr(t, i, 4);
    #2;
    hw = mLookup(t, i);
    expDirty = (hw >= 0) ? mDirty[i*2+hw] : 1'b0;
    check(accHit == (hw >= 0), req, "accHit", int'(accHit), int'(hw >= 0));
    check(accHitDirty == expDirty, req, "accHitDirty", int'(accHitDirty), int'(expDirty));
  endtask

  task automatic probeAll(input string req);
    for (int i = 0; i < 4; i++)
      for (int t = 0; t < 4; t++) probe(t, i, req);
  endtask

  task automatic runAcc(input int t, input int i, input int o, input bit wr);
    int hw;
    hw = mLookup(t, i);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accAddr = mkAddr(t, i, o);
    #2;
    check(accHit == (hw >= 0), "R11", "accHit on access", int'(accHit), int'(hw >= 0));
    @(posedge clk);
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
    if (hw >= 0) begin
      seq++;
      mStamp[i*2+hw] = seq;
      if (wr) mDirty[i*2+hw] = 1'b1;
    end
  endtask

  task automatic runOp(input logic [4:0] code, input int t, input int i,
                       input int o, input bit grant);
    int hw, v, wbW, wbT, l, hold;
    bit launch, invA, instA;
    string req;
    hw = mLookup(t, i);
    launch = 0; invA = 0; instA = 0; wbW = 0; wbT = 0; req = "R10";
    if (!grant) req = "R1";
    else if (code[4]) begin
      case (code[3:0])
        4'd8: begin
          req = "R2";
          if (hw >= 0) mValid[i*2+hw] = 1'b0;
        end
        4'd9, 4'd10, 4'd11, 4'd12: begin
          req = (code[3:0] == 4'd9) ? "R3" : (code[3:0] == 4'd11) ? "R5" : "R4";
          if (hw >= 0 && (mDirty[i*2+hw] || code[3:0] == 4'd11 || code[3:0] == 4'd12)) begin
            launch = 1; wbW = hw; wbT = t;
            invA = (code[3:0] == 4'd10 || code[3:0] == 4'd12);
          end else if (hw >= 0) req = "R5";
        end
        4'd7: begin
          if (hw >= 0) req = "R8";
          else begin
            v = mVictim(i);
            l = i*2 + v;
            if (mValid[l] && mDirty[l]) begin
              req = "R7"; launch = 1; wbW = v; wbT = mTag[l]; instA = 1;
            end else begin
              req = "R6";
              mValid[l] = 1'b1; mDirty[l] = 1'b0; mTag[l] = t;
              seq++; mStamp[l] = seq;
            end
          end
        end
        default: ;
      endcase
    end
    @(negedge clk);
    opStart = 1'b1; opCode = code; opAddr = mkAddr(t, i, o); busGrant = grant;
    #2;
    check(opAccept == grant, "R1", "opAccept", int'(opAccept), int'(grant));
    check(opStall == !grant, "R1", "opStall", int'(opStall), int'(!grant));
    @(posedge clk);
    @(negedge clk);
    opStart = 1'b0; busGrant = 1'b1;
    #2;
    check(wbReq == launch, req, "wbReq after command", int'(wbReq), int'(launch));
    if (launch) begin
      check(wbAddr == mkAddr(wbT, i, 0), req, "wbAddr", int'(wbAddr), int'(mkAddr(wbT, i, 0)));
      check(wbWay == wbW[0], req, "wbWay", int'(wbWay), wbW);
      hold = $urandom % 3;
      repeat (hold) begin
        opStart = 1'b1; opCode = code;
        #2;
        check(!opAccept && opStall, "R9", "stall while busy", int'(opAccept), 0);
        @(posedge clk);
        @(negedge clk);
        opStart = 1'b0;
        #2;
        check(wbReq && wbAddr == mkAddr(wbT, i, 0), "R9", "request held", int'(wbAddr),
              int'(mkAddr(wbT, i, 0)));
      end
      wbDone = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wbDone = 1'b0;
      #2;
      check(!wbReq, "R3", "wbReq released", int'(wbReq), 0);
      l = i*2 + wbW;
      mDirty[l] = 1'b0;
      if (invA) mValid[l] = 1'b0;
      if (instA) begin
        mValid[l] = 1'b1; mTag[l] = t;
        seq++; mStamp[l] = seq;
      end
    end
    probe(t, i, req);
    if (instA) probe(wbT, i, req);
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 8; k++) begin
      mValid[k] = 0; mDirty[k] = 0; mTag[k] = 0; mStamp[k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    check(!wbReq && !opAccept && !opStall, "R1", "reset outputs", int'(wbReq), 0);
    probeAll("R11");

    // directed corners, set 0
    runOp(5'h17, 1, 0, 3, 1);   // R6 install into free way 0
    runOp(5'h17, 2, 0, 8, 1);   // R6 install into free way 1
    runOp(5'h17, 1, 0, 0, 1);   // R8 already present
    runAcc(1, 0, 4, 1);         // R11 mark dirty
    runAcc(2, 0, 0, 0);
    runAcc(3, 0, 0, 1);         // R11 miss: no effect
    runOp(5'h19, 2, 0, 0, 1);   // R5 clean plain writeback: no-op
    runOp(5'h19, 1, 0, 0, 1);   // R3 dirty writeback
    runOp(5'h1b, 2, 0, 0, 1);   // R5 forced on clean
    runOp(5'h1c, 1, 0, 0, 1);   // R4 forced + invalidate
    runAcc(2, 0, 0, 1);
    runOp(5'h17, 3, 0, 0, 1);   // R6 lowest invalid way chosen
    runOp(5'h17, 0, 0, 0, 1);   // R7 oldest dirty victim written back
    runOp(5'h18, 3, 0, 0, 1);   // R2 hit invalidate
    runOp(5'h18, 2, 0, 0, 1);   // R2 miss: no-op
    runOp(5'h10, 0, 0, 0, 1);   // R10 unsupported
    runOp(5'h1d, 0, 0, 0, 1);   // R10 unsupported
    runOp(5'h08, 0, 0, 0, 1);   // R10 other cache
    runOp(5'h18, 0, 0, 0, 0);   // R1 no grant
    probeAll("R10");

    for (int n = 0; n < 300; n++) begin
      int t, i, o;
      logic [4:0] code;
      t = $urandom % 3; i = $urandom % 4; o = $urandom % 16;
      if ($urandom % 10 < 4) runAcc(t, i, o, $urandom % 2);
      else begin
        code[3:0] = ($urandom % 3 == 0) ? 4'($urandom % 16) : 4'(7 + $urandom % 6);
        code[4] = ($urandom % 8 != 0);
        runOp(code, t, i, o, ($urandom % 6 != 0));
      end
      if (n % 25 == 24) probeAll("R11");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule